// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port that software controls through a small word-addressed register interface. Software sets an output value and a per-pin drive enable. It can also read the pad levels, which are synchronized to the block clock, whether or not a pin is driving.

Every pin also watches its synchronized input for a programmable trigger condition: low level, high level, rising edge or falling edge. A detected condition sets that pin's bit in a status register, and software clears the bit by writing a one to it. A mask register decides which status bits reach the interrupt outputs. There is one request line for the lower half of the pins, one for the upper half, and one that combines both.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset, the data, direction, both trigger-configuration and mask registers read zero. `pin_out` and `pin_oe` are all zero and `irq_any` is low.
- R2: A write at byte offset 0x00 sets the output data register, which drives `pin_out`. A write at 0x04 sets the direction register, which drives `pin_oe` (1 = driven, 0 = released). Both read back at the same offsets.
- R3: A read at 0x08 returns `pin_in` after a two-flop synchronizer, whatever the direction. A level applied to `pin_in` can be read from the third read strobe onward, and the first read strobe after the change still returns the old level.
- R4: Each pin has a 2-bit trigger code. Pins 0..15 use offset 0x0C and pins 16..31 use offset 0x10, each at bit 2*(pin mod 16). Code 0 is low level, 1 is high level, 2 is rising edge and 3 is falling edge.
- R5: An edge code sets the pin's status bit once, when the synchronized value differs from its value one cycle earlier in the selected direction. A transition in the other direction leaves the bit unchanged.
- R6: A level code sets the status bit on every cycle in which the synchronized level matches. A cleared bit therefore sets again if the level is still present.
- R7: Status is at offset 0x18. Writing 1 to a bit clears it and writing 0 leaves it unchanged. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R8: Mask is at offset 0x14. `irq_lo` is the OR of status AND mask over pins 0..15, `irq_hi` is the same over pins 16..31, and `irq_any` is their OR.
- R9: Read data is registered and appears on the cycle after the read strobe. Word offsets 0x1C and above read zero, and writes to the pad register at 0x08 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Single-cycle access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables |
| irq_lo | output | 1 | Request for pins 0..15 |
| irq_hi | output | 1 | Request for pins 16..31 |
| irq_any | output | 1 | Combined request |

## Verification
Trigger detection is driven with random trigger codes on all pins together, with a random level before and after a single input step. For each code, the expected status separates a level match that persisted across a clear from a true edge. Directed sequences cover the other cases:
- an edge in the wrong direction, which must leave status alone;
- a clear that collides with a held level, which must leave the bit set;
- a zero write to status, which must change nothing;
- a mask that selects only one half, which must raise only the matching request line.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_code_e;

    // word index = byte offset / 4
    localparam int IDX_DATA   = 0;
    localparam int IDX_DIR    = 1;
    localparam int IDX_PAD    = 2;
    localparam int IDX_CFG_LO = 3;
    localparam int IDX_CFG_HI = 4;
    localparam int IDX_MASK   = 5;
    localparam int IDX_STATUS = 6;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_raw,
    output logic [WIDTH-1:0] pad_now,
    output logic [WIDTH-1:0] pad_last
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] now;
        logic [WIDTH-1:0] last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pad_raw;
        st_d.now  = st_q.meta;
        st_d.last = st_q.now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pad_now  = st_q.now;
    assign pad_last = st_q.last;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   lvl_now,
    input  logic [WIDTH-1:0]   lvl_last,
    input  logic [2*WIDTH-1:0] code_flat,
    output logic [WIDTH-1:0]   hit
);
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        trig_code_e code_p;
        assign code_p = trig_code_e'(code_flat[2*p +: 2]);
        always_comb begin
            unique case (code_p)
                TRIG_LOW:  hit[p] = ~lvl_now[p];
                TRIG_HIGH: hit[p] =  lvl_now[p];
                TRIG_RISE: hit[p] =  lvl_now[p] & ~lvl_last[p];
                TRIG_FALL: hit[p] = ~lvl_now[p] &  lvl_last[p];
                default:   hit[p] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
    import gpio_port_pkg::*;
#(
    parameter int PIN_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic              irq_any
);
    localparam int HALF  = PIN_W / 2;
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [PIN_W-1:0] data;
        logic [PIN_W-1:0] dir;
        logic [PIN_W-1:0] cfg_lo;
        logic [PIN_W-1:0] cfg_hi;
        logic [PIN_W-1:0] mask;
        logic [PIN_W-1:0] status;
        logic [PIN_W-1:0] rdata;
    } port_st_t;

    port_st_t st_d, st_q;

    logic [PIN_W-1:0] lvl_now, lvl_last, hit, pend;
    logic [IDX_W-1:0] widx;
    logic             unused_lsb;
    logic             wr_en, rd_en, wr_status, rd_unmapped;

    assign widx       = bus_addr[ADDR_W-1:2];
    assign unused_lsb = ^bus_addr[1:0];
    assign wr_en      = bus_valid & bus_write;
    assign rd_en      = bus_valid & ~bus_write;
    assign wr_status  = wr_en && (int'(widx) == IDX_STATUS);
    assign rd_unmapped = rd_en && (int'(widx) > IDX_STATUS);

    gpio_pad_sync #(.WIDTH(PIN_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_raw  (pin_in),
        .pad_now  (lvl_now),
        .pad_last (lvl_last)
    );

    gpio_trig_detect #(.WIDTH(PIN_W)) u_detect (
        .lvl_now   (lvl_now),
        .lvl_last  (lvl_last),
        .code_flat ({st_q.cfg_hi, st_q.cfg_lo}),
        .hit       (hit)
    );

    always_comb begin
        logic [PIN_W-1:0] clr;
        st_d = st_q;
        clr  = '0;
        if (wr_en) begin
            case (int'(widx))
                IDX_DATA:   st_d.data   = bus_wdata;
                IDX_DIR:    st_d.dir    = bus_wdata;
                IDX_CFG_LO: st_d.cfg_lo = bus_wdata;
                IDX_CFG_HI: st_d.cfg_hi = bus_wdata;
                IDX_MASK:   st_d.mask   = bus_wdata;
                IDX_STATUS: clr         = bus_wdata;
                default:    ;
            endcase
        end
        // a detection in the same cycle overrides the clear
        st_d.status = (st_q.status & ~clr) | hit;
        if (rd_en) begin
            case (int'(widx))
                IDX_DATA:   st_d.rdata = st_q.data;
                IDX_DIR:    st_d.rdata = st_q.dir;
                IDX_PAD:    st_d.rdata = lvl_now;
                IDX_CFG_LO: st_d.rdata = st_q.cfg_lo;
                IDX_CFG_HI: st_d.rdata = st_q.cfg_hi;
                IDX_MASK:   st_d.rdata = st_q.mask;
                IDX_STATUS: st_d.rdata = st_q.status;
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend      = st_q.status & st_q.mask;
    assign irq_lo    = |pend[HALF-1:0];
    assign irq_hi    = |pend[PIN_W-1:HALF];
    assign irq_any   = irq_lo | irq_hi;
    assign pin_out   = st_q.data;
    assign pin_oe    = st_q.dir;
    assign bus_rdata = st_q.rdata;

    assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(widx) == IDX_DIR) |=> (pin_oe == $past(bus_wdata)));

    assert_hit_sets_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((st_q.status & $past(hit)) == $past(hit)));

    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && hit == '0) |=> ((st_q.status & $past(bus_wdata)) == '0));

    assert_status_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_status && hit == '0) |=> $stable(st_q.status));

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |-> !irq_any);

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unmapped |=> (bus_rdata == '0));
endmodule

// File: tb/gpio_port_irq_tb_top.sv
module gpio_port_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_lo, irq_hi, irq_any;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_port_irq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
    );

    localparam logic [4:0] A_DATA = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
        A_CLO = 5'h0C, A_CHI = 5'h10, A_MASK = 5'h14, A_STAT = 5'h18, A_NONE = 5'h1C;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected status after old level v0 held, clear, then step to v1 (R4..R6)
    function automatic logic exp_bit(input logic [1:0] code, input logic v0, input logic v1);
        case (code)
            2'd0:    return ~v0 | ~v1;
            2'd1:    return v0 | v1;
            2'd2:    return ~v0 & v1;
            default: return v0 & ~v1;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, r2;
        void'($urandom(32'd20240611));
        idle(3);
        // R1: reset state
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 irq_any", {31'h0, irq_any}, 32'h0);
        rst_n = 1'b1;
        idle(2);
        rd(A_DATA, r);  check("R1 data", r, 32'h0);
        rd(A_DIR, r);   check("R1 dir", r, 32'h0);
        rd(A_CLO, r);   check("R1 cfg_lo", r, 32'h0);
        rd(A_CHI, r);   check("R1 cfg_hi", r, 32'h0);
        rd(A_MASK, r);  check("R1 mask", r, 32'h0);

        // R2: data and direction
        wr(A_DATA, 32'hA5A5_0F0F);
        wr(A_DIR, 32'hFFFF_0000);
        check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        rd(A_DATA, r); check("R2 data readback", r, 32'hA5A5_0F0F);
        rd(A_DIR, r);  check("R2 dir readback", r, 32'hFFFF_0000);

        // R3: pad synchronizer latency, independent of direction
        @(negedge clk); pin_in = 32'h1234_5678;
        rd(A_PAD, r); check("R3 first read old", r, 32'h0);
        idle(2);
        rd(A_PAD, r); check("R3 pad level", r, 32'h1234_5678);
        // R9: pad register ignores writes
        wr(A_PAD, 32'hFFFF_FFFF);
        rd(A_PAD, r); check("R9 pad write ignored", r, 32'h1234_5678);
        // R9: unmapped offset reads zero (rdata was nonzero before)
        rd(A_NONE, r); check("R9 unmapped zero", r, 32'h0);

        // R5/R7: rising edges on pins 5 and 21
        @(negedge clk); pin_in = 32'h0;
        idle(4);
        wr(A_CLO, 32'hAAAA_AAAA);
        wr(A_CHI, 32'hAAAA_AAAA);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, r); check("R5 no edge no status", r, 32'h0);
        @(negedge clk); pin_in = (32'h1 << 5) | (32'h1 << 21);
        idle(4);
        rd(A_STAT, r); check("R5 rising sets", r, 32'h0020_0020);
        wr(A_STAT, 32'h0);
        rd(A_STAT, r); check("R7 write zero keeps", r, 32'h0020_0020);
        wr(A_STAT, 32'h0000_0020);
        rd(A_STAT, r); check("R7 write one clears", r, 32'h0020_0000);
        @(negedge clk); pin_in = 32'h0;
        idle(4);
        rd(A_STAT, r); check("R5 falling ignored on rise code", r, 32'h0020_0000);
        // R8: half-specific requests
        wr(A_MASK, 32'h0020_0000);
        check("R8 irq_hi", {31'h0, irq_hi}, 32'h1);
        check("R8 irq_lo", {31'h0, irq_lo}, 32'h0);
        check("R8 irq_any", {31'h0, irq_any}, 32'h1);
        wr(A_MASK, 32'h0000_0020);
        check("R8 masked quiet", {29'h0, irq_any, irq_hi, irq_lo}, 32'h0);

        // R6/R7: low-level trigger on pin 3 (field bits 7:6 of low config)
        wr(A_CLO, 32'hAAAA_AAAA & ~(32'h3 << 6));
        idle(2);
        wr(A_STAT, 32'h0000_0008);
        rd(A_STAT, r); check("R6 level resets after clear (R7 set wins)", r & 32'h8, 32'h8);
        @(negedge clk); pin_in = 32'h0000_0008;
        idle(4);
        wr(A_STAT, 32'h0000_0008);
        rd(A_STAT, r); check("R6 level gone stays clear", r & 32'h8, 32'h0);

        // R4/R5/R6/R8: random trigger codes with one input step
        for (int k = 0; k < 24; k++) begin
            logic [31:0] v0, v1, clo, chi, msk, exp;
            logic [1:0]  code;
            v0 = $urandom; v1 = $urandom; clo = $urandom; chi = $urandom; msk = $urandom;
            if (k == 0) begin v0 = 32'h0; v1 = 32'hFFFF_FFFF; end
            if (k == 1) begin v0 = 32'hFFFF_FFFF; v1 = 32'h0; end
            @(negedge clk); pin_in = v0;
            idle(4);
            wr(A_CLO, clo);
            wr(A_CHI, chi);
            wr(A_MASK, msk);
            idle(2);
            wr(A_STAT, 32'hFFFF_FFFF);
            idle(3);
            @(negedge clk); pin_in = v1;
            idle(6);
            exp = '0;
            for (int p = 0; p < 32; p++) begin
                code = (p < 16) ? clo[2*p +: 2] : chi[2*(p-16) +: 2];
                exp[p] = exp_bit(code, v0[p], v1[p]);
            end
            rd(A_STAT, r);  check("R4 R5 R6 random status", r, exp);
            rd(A_PAD, r2);  check("R3 random pad", r2, v1);
            check("R8 random irq", {29'h0, irq_any, irq_hi, irq_lo},
                  {29'h0, |(exp & msk), |(exp[31:16] & msk[31:16]), |(exp[15:0] & msk[15:0])});
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule